// File: doc/BRIEF.md
# Break and Interrupt Entry Sequencer

This block steps an 8-bit processor core through the entry into its shared interrupt handler. Two sources start it: a decoded software-break opcode and a level-sensitive maskable interrupt request. The break opcode is a single byte with no operand. Even so, the return address it saves lies two bytes past the opcode, so the byte after the break is skipped when the handler returns. A hardware interrupt saves the untouched fetch address, so the interrupted instruction runs again afterwards. The handler tells the two sources apart by one bit in the saved status byte.

The core presents the fetch address, its stack pointer and its status byte at an instruction boundary. When an entry starts, the block owns the bus for seven cycles: the opcode fetch, a dummy read, three stack writes (return address high, return address low, status) into a descending stack in page 0x01, and two vector reads at 0xFFFE and 0xFFFF. It then reports the handler address, the stack pointer lowered by three, and the status byte with interrupt-disable set. The core loads these back into its own registers.

Top module: `intEntrySeq`

## Requirements
- R1: After reset the PC, SP and status outputs are all zero. While idle the bus address follows `fetchAddr`, `busWrite` is low and `busDataOut` is zero.
- R2: For a software break the dummy read in cycle 1 addresses fetchAddr+1, and the saved return address is fetchAddr+2 modulo 2^16.
- R3: For a hardware interrupt the dummy read addresses fetchAddr itself, and the saved return address equals fetchAddr.
- R4: Cycles 2, 3 and 4 write the return high byte at {0x01,SP}, the return low byte at {0x01,SP-1} and the status at {0x01,SP-2}, with the SP byte wrapping modulo 256. Afterwards `spOut` equals SP-3 modulo 256.
- R5: The saved status byte equals the input status with bit 5 forced to 1 and bit 4 replaced: 1 for a software break, 0 for a hardware interrupt.
- R6: Cycle 5 reads 0xFFFE and cycle 6 reads 0xFFFF. Afterwards `pcOut` is {byte read at 0xFFFF, byte read at 0xFFFE}, and `statusOut` is the input status with bit 2 set.
- R7: An interrupt request starts an entry only when `instrBoundary` is high and bit 2 of `statusIn` is clear. Otherwise it causes no bus write and leaves `spOut` unchanged.
- R8: A software break strobe at an instruction boundary starts an entry even when bit 2 of `statusIn` is set.
- R9: When an unmasked interrupt request and the break strobe arrive in the same boundary cycle, the hardware interrupt is taken. The fetch address is then saved unadvanced, with bit 4 clear.
- R10: An entry lasts exactly seven cycles, counting the start cycle. Writes occur only in cycles 2 to 4. Requests that arrive during an entry are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchAddr | input | 16 | Address of the opcode being fetched at the boundary |
| spIn | input | 8 | Core stack pointer at the boundary |
| statusIn | input | 8 | Core status byte; bit 2 is interrupt-disable |
| instrBoundary | input | 1 | High in an opcode-fetch cycle |
| brkDecode | input | 1 | The fetched opcode is the software break |
| irqReq | input | 1 | Maskable hardware interrupt request, level |
| busDataIn | input | 8 | Read data from memory |
| busAddr | output | 16 | Bus address for the current cycle |
| busDataOut | output | 8 | Write data for stack pushes |
| busWrite | output | 1 | High in write cycles |
| spOut | output | 8 | Stack pointer after the last entry |
| pcOut | output | 16 | Program counter after the last entry |
| statusOut | output | 8 | Live status after the last entry |

## Verification
The assertions check on every cycle that writes stay in the stack page and that the saved status always carries bit 5. They check the return address at the moment it is pushed (plus two for a break, unadvanced for an interrupt), and that the stack pointer sits three below its captured value when the vector high byte is read. They also check that interrupt-disable is set after the status push, that a masked request leaves the sequencer idle, that interrupt wins over break, and that an entry cannot be cut short. Only the bench's scenarios show the exact cycle-by-cycle address sequence, the byte values left in stack memory, the wrap of SP and PC at their limits, and the final register values seen from outside.

// File: rtl/intEntryPkg.sv
package intEntryPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DUMMY,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_PUSH_STAT,
    ST_VEC_LO,
    ST_VEC_HI
  } seqState_t;

  typedef enum logic [2:0] {
    A_FETCH,
    A_PC,
    A_STACK,
    A_VEC_LO,
    A_VEC_HI
  } addrSel_t;

  typedef enum logic [1:0] {
    D_NONE,
    D_PC_HI,
    D_PC_LO,
    D_STATUS
  } dataSel_t;

  typedef struct packed {
    logic     loadCtx;
    logic     isBrk;
    logic     incPc;
    logic     pushEn;
    dataSel_t dataSel;
    addrSel_t addrSel;
    logic     setIntDis;
    logic     loadVecLo;
    logic     loadVecHi;
  } seqStrobe_t;

endpackage

// File: rtl/intEntryCtrl.sv
module intEntryCtrl
  import intEntryPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrBoundary,
  input  logic       brkDecode,
  input  logic       irqReq,
  input  logic       intDisable,
  output seqStrobe_t strobe
);

  seqState_t state, stateNext;
  logic      isBrkReg;
  logic      takeIrq, takeBrk, start;

  assign takeIrq = instrBoundary && irqReq && !intDisable;
  assign takeBrk = instrBoundary && brkDecode && !takeIrq;
  assign start   = (state == ST_IDLE) && (takeIrq || takeBrk);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:      if (start) stateNext = ST_DUMMY;
      ST_DUMMY:     stateNext = ST_PUSH_HI;
      ST_PUSH_HI:   stateNext = ST_PUSH_LO;
      ST_PUSH_LO:   stateNext = ST_PUSH_STAT;
      ST_PUSH_STAT: stateNext = ST_VEC_LO;
      ST_VEC_LO:    stateNext = ST_VEC_HI;
      ST_VEC_HI:    stateNext = ST_IDLE;
      default:      stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      isBrkReg <= 1'b0;
    end else begin
      state <= stateNext;
      if (start) isBrkReg <= takeBrk;
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.dataSel   = D_NONE;
    strobe.addrSel   = A_FETCH;
    strobe.isBrk     = isBrkReg;
    case (state)
      ST_IDLE: begin
        strobe.loadCtx = start;
        strobe.isBrk   = takeBrk;
      end
      ST_DUMMY: begin
        strobe.addrSel = A_PC;
        strobe.incPc   = isBrkReg;
      end
      ST_PUSH_HI: begin
        strobe.addrSel = A_STACK;
        strobe.pushEn  = 1'b1;
        strobe.dataSel = D_PC_HI;
      end
      ST_PUSH_LO: begin
        strobe.addrSel = A_STACK;
        strobe.pushEn  = 1'b1;
        strobe.dataSel = D_PC_LO;
      end
      ST_PUSH_STAT: begin
        strobe.addrSel   = A_STACK;
        strobe.pushEn    = 1'b1;
        strobe.dataSel   = D_STATUS;
        strobe.setIntDis = 1'b1;
      end
      ST_VEC_LO: begin
        strobe.addrSel   = A_VEC_LO;
        strobe.loadVecLo = 1'b1;
      end
      ST_VEC_HI: begin
        strobe.addrSel   = A_VEC_HI;
        strobe.loadVecHi = 1'b1;
      end
      default: ;
    endcase
  end

  // R7: a masked request with no break leaves the sequencer idle
  a_r7_masked_irq_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && instrBoundary && irqReq && intDisable && !brkDecode)
      |=> (state == ST_IDLE));

  // R9: both sources at once enter as a hardware interrupt
  a_r9_irq_wins: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && instrBoundary && irqReq && !intDisable && brkDecode)
      |=> (state == ST_DUMMY && !isBrkReg));

  // R10: once started an entry runs to the vector high read without returning early
  a_r10_no_early_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && state != ST_VEC_HI) |=> (state != ST_IDLE));

  // R10: the cycle after the vector high read is idle again
  a_r10_ends_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_VEC_HI) |=> (state == ST_IDLE));

endmodule

// File: rtl/intEntryPath.sv
module intEntryPath
  import intEntryPkg::*;
#(
  parameter int          DataW       = 8,
  parameter int          IntDisBit   = 2,
  parameter int          BreakBit    = 4,
  parameter int          FixedOneBit = 5,
  parameter logic [7:0]  StackPage   = 8'h01,
  parameter logic [15:0] VectorBase  = 16'hFFFE
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic [2*DataW-1:0]   fetchAddr,
  input  logic [DataW-1:0]     spIn,
  input  logic [DataW-1:0]     statusIn,
  input  logic [DataW-1:0]     busDataIn,
  output logic [2*DataW-1:0]   busAddr,
  output logic [DataW-1:0]     busDataOut,
  output logic                 busWrite,
  output logic [DataW-1:0]     spOut,
  output logic [2*DataW-1:0]   pcOut,
  output logic [DataW-1:0]     statusOut
);

  localparam int AddrW = 2 * DataW;
  localparam logic [AddrW-1:0] VecLoAddr = VectorBase;
  localparam logic [AddrW-1:0] VecHiAddr = VectorBase + AddrW'(1);

  logic [AddrW-1:0] pcReg, pcSave;
  logic [DataW-1:0] spReg, spSave;
  logic [DataW-1:0] statReg;
  logic [DataW-1:0] pushedStat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcReg   <= '0;
      pcSave  <= '0;
      spReg   <= '0;
      spSave  <= '0;
      statReg <= '0;
    end else begin
      if (strobe.loadCtx) begin
        pcReg   <= strobe.isBrk ? fetchAddr + AddrW'(1) : fetchAddr;
        pcSave  <= fetchAddr;
        spReg   <= spIn;
        spSave  <= spIn;
        statReg <= statusIn;
      end
      if (strobe.incPc)     pcReg <= pcReg + AddrW'(1);
      if (strobe.pushEn)    spReg <= spReg - DataW'(1);
      if (strobe.setIntDis) statReg[IntDisBit] <= 1'b1;
      if (strobe.loadVecLo) pcReg[DataW-1:0] <= busDataIn;
      if (strobe.loadVecHi) pcReg[AddrW-1:DataW] <= busDataIn;
    end
  end

  always_comb begin
    pushedStat              = statReg;
    pushedStat[FixedOneBit] = 1'b1;
    pushedStat[BreakBit]    = strobe.isBrk;
  end

  always_comb begin
    case (strobe.addrSel)
      A_PC:     busAddr = pcReg;
      A_STACK:  busAddr = {StackPage, spReg};
      A_VEC_LO: busAddr = VecLoAddr;
      A_VEC_HI: busAddr = VecHiAddr;
      default:  busAddr = fetchAddr;
    endcase
    case (strobe.dataSel)
      D_PC_HI:  busDataOut = pcReg[AddrW-1:DataW];
      D_PC_LO:  busDataOut = pcReg[DataW-1:0];
      D_STATUS: busDataOut = pushedStat;
      default:  busDataOut = '0;
    endcase
  end

  assign busWrite  = strobe.pushEn;
  assign spOut     = spReg;
  assign pcOut     = pcReg;
  assign statusOut = statReg;

  // R4: every write lands in the stack page
  a_r4_stack_page: assert property (@(posedge clk) disable iff (!rstN)
    busWrite |-> (busAddr[AddrW-1:DataW] == StackPage));

  // R5: the saved status byte always carries the fixed one bit
  a_r5_fixed_bit: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && strobe.dataSel == D_STATUS) |-> busDataOut[FixedOneBit]);

  // R2: a break pushes the fetch address advanced by two
  a_r2_plus_two: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pushEn && strobe.dataSel == D_PC_HI && strobe.isBrk)
      |-> (pcReg == pcSave + AddrW'(2)));

  // R3: a hardware interrupt pushes the fetch address unchanged
  a_r3_unadvanced: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pushEn && strobe.dataSel == D_PC_HI && !strobe.isBrk)
      |-> (pcReg == pcSave));

  // R4: three pushes have happened by the vector high read
  a_r4_sp_minus_three: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadVecHi |-> (spReg == spSave - DataW'(3)));

  // R6: interrupt-disable is set after the status push
  a_r6_intdis_set: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setIntDis |=> statReg[IntDisBit]);

endmodule

// File: rtl/intEntrySeq.sv
module intEntrySeq
  import intEntryPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] fetchAddr,
  input  logic [7:0]  spIn,
  input  logic [7:0]  statusIn,
  input  logic        instrBoundary,
  input  logic        brkDecode,
  input  logic        irqReq,
  input  logic [7:0]  busDataIn,
  output logic [15:0] busAddr,
  output logic [7:0]  busDataOut,
  output logic        busWrite,
  output logic [7:0]  spOut,
  output logic [15:0] pcOut,
  output logic [7:0]  statusOut
);

  localparam int IntDisBit = 2;

  seqStrobe_t strobe;

  intEntryCtrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .instrBoundary (instrBoundary),
    .brkDecode     (brkDecode),
    .irqReq        (irqReq),
    .intDisable    (statusIn[IntDisBit]),
    .strobe        (strobe)
  );

  intEntryPath #(
    .DataW     (8),
    .IntDisBit (IntDisBit)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .fetchAddr  (fetchAddr),
    .spIn       (spIn),
    .statusIn   (statusIn),
    .busDataIn  (busDataIn),
    .busAddr    (busAddr),
    .busDataOut (busDataOut),
    .busWrite   (busWrite),
    .spOut      (spOut),
    .pcOut      (pcOut),
    .statusOut  (statusOut)
  );

endmodule

// File: tb/intEntrySeq_bench.sv
module intEntrySeq_bench;

  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] fetchAddr = 16'h1234;
  logic [7:0]  spIn = 8'h00;
  logic [7:0]  statusIn = 8'h00;
  logic        instrBoundary = 1'b0;
  logic        brkDecode = 1'b0;
  logic        irqReq = 1'b0;
  logic [7:0]  busDataIn;
  logic [15:0] busAddr;
  logic [7:0]  busDataOut;
  logic        busWrite;
  logic [7:0]  spOut;
  logic [15:0] pcOut;
  logic [7:0]  statusOut;

  logic [7:0]  vecLo = 8'h00;
  logic [7:0]  vecHi = 8'h00;
  logic [7:0]  stackMem [256];

  int total = 0;
  int bad = 0;
  bit summaryDone = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  assign busDataIn = (busAddr == 16'hFFFE) ? vecLo :
                     (busAddr == 16'hFFFF) ? vecHi : 8'hEA;

  intEntrySeq u_intEntrySeq (
    .clk(clk), .rstN(rstN), .fetchAddr(fetchAddr), .spIn(spIn),
    .statusIn(statusIn), .instrBoundary(instrBoundary), .brkDecode(brkDecode),
    .irqReq(irqReq), .busDataIn(busDataIn), .busAddr(busAddr),
    .busDataOut(busDataOut), .busWrite(busWrite), .spOut(spOut),
    .pcOut(pcOut), .statusOut(statusOut)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drives one entry from a negedge and checks the whole sequence.
  task automatic runEntry(input logic [15:0] pc, input logic [7:0] sp,
                          input logic [7:0] st, input logic brk, input logic irq,
                          input logic [7:0] vl, input logic [7:0] vh);
    logic [15:0] addrSeen [7];
    logic        wrSeen [7];
    logic        expBrk;
    logic [15:0] ret;
    logic [7:0]  expStat;
    expBrk = !(irq && !st[2]);
    ret = expBrk ? pc + 16'd2 : pc;
    expStat = (st | 8'h20) & 8'hEF;
    if (expBrk) expStat = expStat | 8'h10;
    vecLo = vl; vecHi = vh;
    fetchAddr = pc; spIn = sp; statusIn = st;
    instrBoundary = 1'b1; brkDecode = brk; irqReq = irq;
    #1;
    addrSeen[0] = busAddr; wrSeen[0] = busWrite;
    for (int c = 1; c < 7; c++) begin
      @(negedge clk);
      brkDecode = 1'b0;
      addrSeen[c] = busAddr; wrSeen[c] = busWrite;
      if (busWrite) stackMem[busAddr[7:0]] = busDataOut;
    end
    @(negedge clk);
    instrBoundary = 1'b0; irqReq = 1'b0;
    #1;
    check(addrSeen[0] == pc, "R1 fetch address", addrSeen[0], pc);
    check(addrSeen[1] == (expBrk ? pc + 16'd1 : pc),
          expBrk ? "R2 dummy read" : "R3 dummy read", addrSeen[1],
          expBrk ? pc + 16'd1 : pc);
    check(addrSeen[2] == {8'h01, sp}, "R4 push hi addr", addrSeen[2], {8'h01, sp});
    check(addrSeen[3] == {8'h01, sp - 8'd1}, "R4 push lo addr", addrSeen[3],
          {8'h01, sp - 8'd1});
    check(addrSeen[4] == {8'h01, sp - 8'd2}, "R4 push stat addr", addrSeen[4],
          {8'h01, sp - 8'd2});
    check(addrSeen[5] == 16'hFFFE, "R6 vector lo addr", addrSeen[5], 16'hFFFE);
    check(addrSeen[6] == 16'hFFFF, "R6 vector hi addr", addrSeen[6], 16'hFFFF);
    for (int c = 0; c < 7; c++)
      check(wrSeen[c] == (c >= 2 && c <= 4), "R10 write cycles",
            {15'd0, wrSeen[c]}, {15'd0, (c >= 2 && c <= 4)});
    check(stackMem[sp] == ret[15:8],
          expBrk ? "R2 stacked ret hi" : "R3 stacked ret hi",
          {8'h0, stackMem[sp]}, {8'h0, ret[15:8]});
    check(stackMem[sp - 8'd1] == ret[7:0],
          expBrk ? "R2 stacked ret lo" : "R3 stacked ret lo",
          {8'h0, stackMem[sp - 8'd1]}, {8'h0, ret[7:0]});
    check(stackMem[sp - 8'd2] == expStat, "R5 stacked status",
          {8'h0, stackMem[sp - 8'd2]}, {8'h0, expStat});
    check(spOut == sp - 8'd3, "R4 final sp", {8'h0, spOut}, {8'h0, sp - 8'd3});
    check(pcOut == {vh, vl}, "R6 loaded vector", pcOut, {vh, vl});
    check(statusOut == (st | 8'h04), "R6 live status", {8'h0, statusOut},
          {8'h0, st | 8'h04});
    check(busAddr == pc && !busWrite, "R10 back to idle", busAddr, pc);
  endtask

  task automatic testReset();
    check(busAddr == 16'h1234, "R1 idle address", busAddr, 16'h1234);
    check(!busWrite && busDataOut == 8'h00, "R1 idle no write",
          {7'd0, busWrite, busDataOut}, 16'h0);
    check(pcOut == 16'h0, "R1 reset pc", pcOut, 16'h0);
    check(spOut == 8'h0, "R1 reset sp", {8'h0, spOut}, 16'h0);
    check(statusOut == 8'h0, "R1 reset status", {8'h0, statusOut}, 16'h0);
  endtask

  task automatic testBreak();
    runEntry(16'h0300, 8'hFF, 8'h01, 1'b1, 1'b0, 8'h40, 8'hC0); // R2 R5 break
  endtask

  task automatic testIrq();
    // R3, R10: request held high during the entry must not restart it
    runEntry(16'h4567, 8'hF0, 8'hC3, 1'b0, 1'b1, 8'h11, 8'hE2);
  endtask

  task automatic testBreakMasked();
    runEntry(16'h2000, 8'h80, 8'h04, 1'b1, 1'b0, 8'h55, 8'hAA); // R8
  endtask

  task automatic testBoth();
    runEntry(16'h0A0B, 8'h70, 8'h00, 1'b1, 1'b1, 8'h22, 8'hF3); // R9 irq wins
  endtask

  task automatic testWrap();
    runEntry(16'hFFFF, 8'h01, 8'h80, 1'b1, 1'b0, 8'h01, 8'h02); // R2 R4 wraps
  endtask

  task automatic idleWatch(input string tag, input logic [7:0] spHeld);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check(!busWrite && busAddr == fetchAddr, tag, busAddr, fetchAddr);
    end
    check(spOut == spHeld, tag, {8'h0, spOut}, {8'h0, spHeld});
  endtask

  task automatic testMaskedIrq();
    logic [7:0] spHeld;
    spHeld = spOut;
    fetchAddr = 16'h5000; spIn = 8'h33; statusIn = 8'h04;
    instrBoundary = 1'b1; irqReq = 1'b1; brkDecode = 1'b0;
    idleWatch("R7 masked request", spHeld);
    irqReq = 1'b0; instrBoundary = 1'b0;
  endtask

  task automatic testNoBoundary();
    logic [7:0] spHeld;
    spHeld = spOut;
    fetchAddr = 16'h5100; spIn = 8'h44; statusIn = 8'h00;
    instrBoundary = 1'b0; irqReq = 1'b1; brkDecode = 1'b0;
    idleWatch("R7 no boundary", spHeld);
    irqReq = 1'b0;
  endtask

  initial begin
    #(ClkPeriod * 20000);
    if (!summaryDone) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summaryDone = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) stackMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testBreak();
    testIrq();
    testMaskedIrq();
    testBreakMasked();
    testNoBoundary();
    testBoth();
    testWrap();
    repeat (2) @(negedge clk);
    summaryDone = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule